// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word addresses for a synchronous burst read from a memory array. A one-cycle start request loads a start address, a burst-length code, a no-wrap bit and a latency count. From the following clock the block presents one address per cycle, marked by a data-valid strobe, until the burst is complete. The array itself and the first-access latency are handled elsewhere. The latency count is used only to size a row-crossing stall.

A fixed burst is 4, 8 or 16 words long. It either wraps inside the aligned block of that size or steps linearly past its end. A continuous burst always steps linearly. It runs until the top of the address space, or until the stop input is raised on a valid word. In linear operation, the first step across a 16-word row boundary can cost a stall. The length of that stall depends on where the burst began within its 4-word group. During the stall the block raises its wait output and withholds data-valid.

Top module: `burst_addr_seq`

## Requirements
- R1: Length code 0, 1 and 2 give fixed bursts of 4, 8 and 16 valid words. The first word appears in the cycle after the start request is accepted. The done output pulses together with the last valid word, and the block is idle in the following cycle.
- R2: When the no-wrap input is 0, a fixed burst visits the aligned block of its own length that holds the start address. It steps upward and wraps from the top of that block to its base.
- R3: When the no-wrap input is 1, a fixed burst steps upward by one address per valid word, past the block boundary.
- R4: Length code 3 selects a continuous burst. It steps linearly whatever the no-wrap input says, and it ends with done on the all-ones address.
- R5: A stop input that is high on a valid word of a continuous burst makes that word the last one, with done. During a fixed burst the stop input has no effect.
- R6: In linear operation, a burst whose start address has its two low bits equal to 0 crosses a row boundary with no stall.
- R7: For a start offset k (k = 1 to 3) within the 4-word group, the stall is max(0, L + k − 4) cycles for latency L. It follows the valid word whose address has its low four bits equal to 15.
- R8: At most one stall occurs per burst, at the first row crossing only. There is no stall when the burst ends on a row's last word, and none in wrap mode.
- R9: During each stall cycle, wait is 1, data-valid is 0 and the presented address is held.
- R10: A start request that arrives while a burst is in progress is ignored. The running burst's addresses and length are unchanged.
- R11: After reset, and whenever no burst is running, busy, data-valid, wait and done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start pulse, accepted only while idle |
| startAddr | input | ADDR_W | First word address |
| lenCode | input | 2 | 0: 4 words, 1: 8, 2: 16, 3: continuous |
| noWrap | input | 1 | 1: linear fixed bursts, 0: wrap in the aligned block |
| latency | input | LAT_W | Latency count used to size the row-crossing stall |
| stopReq | input | 1 | Ends a continuous burst on the current valid word |
| addrOut | output | ADDR_W | Current word address |
| dataValid | output | 1 | Address is a valid burst word |
| waitOut | output | 1 | Row-crossing stall in progress |
| burstDone | output | 1 | Last valid word of the burst |
| busy | output | 1 | Burst in progress |

## Verification
Two things are hardest to reach from the ports. One is a row-crossing stall whose length depends on both the start offset and the latency. The other is the check that no second stall occurs. Directed bursts cover offsets 0 to 3 against large and small latencies. They also cover a burst that ends exactly on a row's last word, and a continuous burst that crosses two row boundaries. Random bursts then change the length, wrap bit, offset and latency, and raise start requests during every burst. A bench model predicts the expected stall position and length cycle by cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int ROW_BITS   = 4;
  localparam int GROUP_BITS = 2;
  localparam int CNT_W      = ROW_BITS + 1;

  typedef enum logic [1:0] {
    LEN_4    = 2'd0,
    LEN_8    = 2'd1,
    LEN_16   = 2'd2,
    LEN_CONT = 2'd3
  } lenCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobes_t;
endpackage

// File: rtl/bsq_datapath.sv
module bsq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [1:0]        lenCode,
  input  logic              noWrap,
  input  logic [LAT_W-1:0]  latency,
  output logic [ADDR_W-1:0] addr,
  output logic              rowEnd,
  output logic              topEnd,
  output logic              isCont,
  output logic              linear,
  output logic [LAT_W-1:0]  stallLen,
  output logic [CNT_W-1:0]  lenM1
);
  lenCode_e                lenQ;
  logic                    noWrapQ;
  logic [LAT_W-1:0]        latQ;
  logic [GROUP_BITS-1:0]   offQ;
  logic [ROW_BITS-1:0]     mask;
  logic [ROW_BITS-1:0]     lowInc;
  logic [ADDR_W-1:0]       nextAddr;
  logic [LAT_W:0]          stallSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ    <= LEN_4;
      noWrapQ <= 1'b1;
      latQ    <= '0;
      offQ    <= '0;
      addr    <= '0;
    end else if (strobes.load) begin
      lenQ    <= lenCode_e'(lenCode);
      noWrapQ <= noWrap;
      latQ    <= latency;
      offQ    <= startAddr[GROUP_BITS-1:0];
      addr    <= startAddr;
    end else if (strobes.step) begin
      addr    <= nextAddr;
    end
  end

  always_comb begin
    isCont   = (lenQ == LEN_CONT);
    linear   = noWrapQ || isCont;
    lenM1    = isCont ? '1 : CNT_W'((5'd4 << lenQ) - 5'd1);
    mask     = lenM1[ROW_BITS-1:0];
    lowInc   = addr[ROW_BITS-1:0] + 1'b1;
    if (linear)
      nextAddr = addr + 1'b1;
    else
      nextAddr = {addr[ADDR_W-1:ROW_BITS],
                  (addr[ROW_BITS-1:0] & ~mask) | (lowInc & mask)};
    rowEnd   = &addr[ROW_BITS-1:0];
    topEnd   = &addr;
    stallSum = {1'b0, latQ} + (LAT_W+1)'(offQ);
    if (offQ == '0 || stallSum <= (LAT_W+1)'(4))
      stallLen = '0;
    else
      stallLen = LAT_W'(stallSum - (LAT_W+1)'(4));
  end
endmodule

// File: rtl/bsq_control.sv
module bsq_control
  import burst_seq_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic             rowEnd,
  input  logic             topEnd,
  input  logic             isCont,
  input  logic             linear,
  input  logic [LAT_W-1:0] stallLen,
  input  logic [CNT_W-1:0] lenM1,
  output seqStrobes_t      strobes,
  output logic             busy,
  output logic             dataValid,
  output logic             waitOut,
  output logic             burstDone
);
  logic [CNT_W-1:0] cnt;
  logic [LAT_W-1:0] stallCnt;
  logic             crossed;
  logic             lastWord;

  always_comb begin
    dataValid    = busy && (stallCnt == '0);
    waitOut      = busy && (stallCnt != '0);
    lastWord     = isCont ? (topEnd || stopReq) : (cnt == lenM1);
    burstDone    = dataValid && lastWord;
    strobes.load = !busy && startReq;
    strobes.step = dataValid && !lastWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      stallCnt <= '0;
      crossed  <= 1'b0;
    end else if (strobes.load) begin
      busy     <= 1'b1;
      cnt      <= '0;
      stallCnt <= '0;
      crossed  <= 1'b0;
    end else if (waitOut) begin
      stallCnt <= stallCnt - 1'b1;
    end else if (burstDone) begin
      busy     <= 1'b0;
    end else if (strobes.step) begin
      cnt <= cnt + 1'b1;
      if (rowEnd && linear && !crossed) begin
        crossed  <= 1'b1;
        stallCnt <= stallLen;
      end
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [1:0]        lenCode,
  input  logic              noWrap,
  input  logic [LAT_W-1:0]  latency,
  input  logic              stopReq,
  output logic [ADDR_W-1:0] addrOut,
  output logic              dataValid,
  output logic              waitOut,
  output logic              burstDone,
  output logic              busy
);
  seqStrobes_t      strobes;
  logic             rowEnd, topEnd, isCont, linear;
  logic [LAT_W-1:0] stallLen;
  logic [CNT_W-1:0] lenM1;

  bsq_datapath #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startAddr(startAddr),
    .lenCode(lenCode), .noWrap(noWrap), .latency(latency), .addr(addrOut),
    .rowEnd(rowEnd), .topEnd(topEnd), .isCont(isCont), .linear(linear),
    .stallLen(stallLen), .lenM1(lenM1)
  );

  bsq_control #(.LAT_W(LAT_W)) i_control (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .rowEnd(rowEnd), .topEnd(topEnd), .isCont(isCont), .linear(linear),
    .stallLen(stallLen), .lenM1(lenM1), .strobes(strobes), .busy(busy),
    .dataValid(dataValid), .waitOut(waitOut), .burstDone(burstDone)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              dataValid,
  input logic              waitOut,
  input logic              burstDone,
  input logic [ADDR_W-1:0] addrOut
);
  logic waitSeen;
  logic waitPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitSeen <= 1'b0;
      waitPrev <= 1'b0;
    end else begin
      waitPrev <= waitOut;
      if (!busy) waitSeen <= 1'b0;
      else if (waitOut) waitSeen <= 1'b1;
    end
  end

  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !busy); // R1
  AST_STALL_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    waitOut |-> (!dataValid && !burstDone)); // R9
  AST_STALL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && waitOut) |=> $stable(addrOut)); // R9
  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (waitOut && !waitPrev) |-> !waitSeen); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!dataValid && !waitOut && !burstDone)); // R11
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .dataValid(dataValid),
  .waitOut(waitOut), .burstDone(burstDone), .addrOut(addrOut)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [1:0]    lenCode = '0;
  logic          noWrap = 1'b1;
  logic [LW-1:0] latency = '0;
  logic          stopReq = 1'b0;
  logic [AW-1:0] addrOut;
  logic          dataValid, waitOut, burstDone, busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .LAT_W(LW)) i_burst_addr_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .lenCode(lenCode), .noWrap(noWrap), .latency(latency), .stopReq(stopReq),
    .addrOut(addrOut), .dataValid(dataValid), .waitOut(waitOut),
    .burstDone(burstDone), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expAddr(int s, int code, bit nw, int i);
    int m;
    if (nw || code == 3) return (s + i) % (1 << AW);
    m = (4 << code) - 1;
    return (s & ~m) | ((s + i) & m);
  endfunction

  function automatic int expStall(int s, int lat);
    int off = s & 3;
    if (off == 0) return 0;
    return (lat + off > 4) ? lat + off - 4 : 0;
  endfunction

  // runs one burst; stopIdx < 0 means no stop; junk drives start requests mid-burst
  task automatic runBurst(input int s, input int code, input bit nw, input int lat,
                          input int stopIdx, input bit junk, input string tag);
    int n, idx, stallLeft, stallSeen, expTot;
    bit crossed, lin, done;
    lin = nw || (code == 3);
    if (code < 3) n = 4 << code;
    else if (stopIdx >= 0) n = stopIdx + 1;
    else n = (1 << AW) - s;
    @(negedge clk);
    startReq = 1'b1; startAddr = AW'(s); lenCode = 2'(code);
    noWrap = nw; latency = LW'(lat);
    @(negedge clk);
    idx = 0; stallLeft = 0; stallSeen = 0; crossed = 0; done = 0; expTot = 0;
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      startReq = junk ? 1'($urandom_range(0, 1)) : 1'b0;
      if (junk) begin
        startAddr = AW'($urandom); lenCode = 2'($urandom);
        noWrap = 1'($urandom); latency = LW'($urandom);
      end
      stopReq = (stallLeft == 0 && stopIdx >= 0 && idx == stopIdx);
      #1;
      if (stallLeft > 0) begin
        check(waitOut && !dataValid && !burstDone && addrOut == AW'(expAddr(s, code, nw, idx)),
              "R9 stall", {waitOut, dataValid, burstDone, addrOut},
              {1'b1, 1'b0, 1'b0, AW'(expAddr(s, code, nw, idx))});
        stallLeft--; stallSeen++;
      end else begin
        check(dataValid && !waitOut && busy && addrOut == AW'(expAddr(s, code, nw, idx))
              && burstDone == (idx == n - 1),
              tag, {dataValid, waitOut, burstDone, addrOut},
              {1'b1, 1'b0, 1'(idx == n - 1), AW'(expAddr(s, code, nw, idx))});
        if (idx == n - 1) done = 1;
        else begin
          if (lin && !crossed && (expAddr(s, code, nw, idx) & 15) == 15) begin
            crossed = 1; stallLeft = expStall(s, lat); expTot = stallLeft;
          end
          idx++;
        end
      end
      @(negedge clk);
    end
    startReq = 1'b0; stopReq = 1'b0;
    #1;
    check(done && !busy && !dataValid && !waitOut, "R1 idle after done",
          {done, busy, dataValid, waitOut}, 4'b1000);
    check(stallSeen == expTot,
          !crossed ? "R8 no crossing" : ((s & 3) == 0 ? "R6 aligned" : "R7 stall length"),
          stallSeen, expTot);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!busy && !dataValid && !waitOut && !burstDone, "R11 reset",
          {busy, dataValid, waitOut, burstDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !dataValid && !waitOut && !burstDone, "R11 after reset",
          {busy, dataValid, waitOut, burstDone}, 0);
    runBurst(8'h20, 2, 1, 5, -1, 0, "R1 len16");
    runBurst(8'h23, 1, 0, 5, -1, 0, "R2 wrap8");
    runBurst(8'h2E, 2, 0, 9, -1, 0, "R2 R8 wrap16");
    runBurst(8'h41, 0, 0, 9, -1, 0, "R2 wrap4");
    runBurst(8'h2D, 1, 1, 6, -1, 0, "R3 linear8");
    runBurst(8'h2F, 0, 1, 6, -1, 0, "R3 offset3");
    runBurst(8'h2E, 0, 1, 3, -1, 0, "R3 offset2");
    runBurst(8'h2C, 2, 1, 7, -1, 0, "R6 aligned");
    runBurst(8'h3D, 0, 1, 1, -1, 0, "R7 small latency");
    runBurst(8'h3C, 0, 1, 9, -1, 0, "R8 ends on row end");
    runBurst(8'hE3, 3, 0, 4, -1, 0, "R4 continuous to top");
    runBurst(8'h17, 3, 1, 4, 30, 0, "R5 R8 stop continuous");
    runBurst(8'h40, 1, 1, 4, 2, 0, "R5 stop ignored fixed");
    runBurst(8'h5B, 2, 1, 8, -1, 1, "R10 start ignored");
    for (int k = 0; k < 40; k++) begin
      int s, code, lat, stp;
      bit nw;
      s = $urandom_range(0, 200); code = $urandom_range(0, 3);
      nw = 1'($urandom); lat = $urandom_range(0, 15);
      stp = (code == 3) ? $urandom_range(0, 25) : -1;
      if (stp >= 256 - s) stp = -1;
      runBurst(s, code, nw, lat, stp, 1, "R10 random");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule